// File: doc/BRIEF.md
# Edge Phase Timestamp Capture

This block marks every transition of an NRZ serial data input with the position of that transition inside the unit interval. The block's clock is the fast phase clock, which runs at 2^PHASE_W times the baud rate. On that clock a free-running PHASE_W-bit phase counter wraps exactly once per bit period. Each rising or falling data edge latches a phase word into an output register and raises a one-cycle valid strobe. The register also records the new data level. One LSB of the phase word is worth 2^-PHASE_W UI.

A second phase source takes the phase from a delay line rather than from the counter. In that mode the data edge captures a snapshot of 2^PHASE_W delay-line tap outputs. The snapshot is read as a thermometer code and converted to a binary phase. The converter finds the first position where the code drops from 1 to 0 and ignores any stray 1 bits that come after it. A select input picks the phase source on each edge. Downstream logic such as phase unwrapping and filtering reads the timestamps.

Top module: `edge_phase_stamp`

## Requirements
- R1: A synchronous active-high reset clears stamp_valid, stamp_phase and stamp_rising to 0 and restarts the phase counter at 0. The first clock edge after reset is released samples phase 0.
- R2: In counter mode (src_tap = 0), the phase that is captured equals the number of clock edges since reset release, modulo 2^PHASE_W. Edges that are 2^PHASE_W cycles apart carry the same phase.
- R3: A 0-to-1 data transition produces a timestamp with stamp_rising = 1.
- R4: A 1-to-0 data transition produces a timestamp with stamp_rising = 0.
- R5: stamp_valid is high for exactly one cycle per transition, one cycle after the clock edge that samples the new level. It stays low while the data input holds its level.
- R6: Transitions on consecutive clock samples each produce their own timestamp. stamp_valid stays high and stamp_rising alternates.
- R7: In tap mode (src_tap = 1), the captured phase equals the count of consecutive 1 bits starting at tap_snap[0]. A snapshot with tap_snap[0] = 0 gives phase 0.
- R8: A tap snapshot that is all ones saturates to phase 2^PHASE_W - 1.
- R9: In tap mode, 1 bits that appear above the first 0 bit do not change the captured phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock, 2^PHASE_W times the baud rate |
| rst | input | 1 | Synchronous active-high reset |
| data_in | input | 1 | NRZ data under measurement, already in the clk domain |
| src_tap | input | 1 | Phase source select: 0 = counter, 1 = tap snapshot |
| tap_snap | input | 2^PHASE_W | Delay-line tap snapshot, thermometer code with bit 0 first |
| stamp_valid | output | 1 | One-cycle strobe for each captured transition |
| stamp_phase | output | PHASE_W | Phase of the transition inside the UI |
| stamp_rising | output | 1 | Level after the transition (1 = rising edge) |

## Verification
Three events can land in one cycle: a data transition, the counter wrapping from 2^PHASE_W - 1 to 0, and the valid strobe of the transition before it. The bench provokes this in two ways. It toggles data on back-to-back cycles around the wrap point, and it runs a random pattern whose toggle rate is high enough that such cycles recur often. Every output cycle is judged against a cycle counter the bench keeps since reset. In each such cycle the check requires that the valid strobe stays high, that the rising flag flips, and that the phase is the wrapped count and not a stale or skipped value.

// File: rtl/edge_ts_pkg.sv
package edge_ts_pkg;

    // Default phase resolution: 2^5 = 32 steps per unit interval
    localparam int DEF_PHASE_W = 5;

    // Which phase source feeds the timestamp register
    typedef enum logic {
        SRC_COUNT = 1'b0,
        SRC_TAPS  = 1'b1
    } phase_src_e;

    // Edge detector output carried to the capture register
    typedef struct packed {
        logic seen;   // a transition was sampled this cycle
        logic level;  // level the data moved to
    } edge_ev_t;

    // Number of phase steps for a given counter width
    function automatic int unsigned steps_of(input int unsigned w);
        return 32'd1 << w;
    endfunction

endpackage

// File: rtl/phase_counter.sv
module phase_counter #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    output logic [W-1:0] phase
);
    // Free running; with a power-of-two range the natural wrap is one UI
    always_ff @(posedge clk) begin
        if (rst) phase <= '0;
        else     phase <= phase + 1'b1;
    end
endmodule

// File: rtl/edge_detect.sv
module edge_detect
    import edge_ts_pkg::*;
(
    input  logic     clk,
    input  logic     din,
    output edge_ev_t ev
);
    logic prev_q;

    // Tracks the input during reset too, so release raises no false edge
    always_ff @(posedge clk) begin
        prev_q <= din;
    end

    always_comb begin
        ev.seen  = din ^ prev_q;
        ev.level = din;
    end
endmodule

// File: rtl/therm_coder.sv
module therm_coder #(
    parameter int W    = 5,
    parameter int TAPS = 32
) (
    input  logic [TAPS-1:0] taps,
    output logic [W-1:0]    code
);
    // run[i] stays high only while every tap from 0 to i is high,
    // so anything past the first zero is masked out
    logic [TAPS-1:0] run;
    logic [W:0]      ones;

    assign run[0] = taps[0];
    generate
        for (genvar i = 1; i < TAPS; i++) begin : g_run
            assign run[i] = run[i-1] & taps[i];
        end
    endgenerate

    always_comb begin
        ones = '0;
        for (int i = 0; i < TAPS; i++) begin
            ones = ones + {{W{1'b0}}, run[i]};
        end
        // A full count of TAPS needs the extra bit; clamp it to the top step
        if (ones[W]) code = '1;
        else         code = ones[W-1:0];
    end
endmodule

// File: rtl/edge_phase_stamp.sv
module edge_phase_stamp
    import edge_ts_pkg::*;
#(
    parameter int PHASE_W = DEF_PHASE_W,
    parameter int TAPS    = int'(steps_of(PHASE_W))
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               data_in,
    input  logic               src_tap,
    input  logic [TAPS-1:0]    tap_snap,
    output logic               stamp_valid,
    output logic [PHASE_W-1:0] stamp_phase,
    output logic               stamp_rising
);
    logic [PHASE_W-1:0] cnt_phase;
    logic [PHASE_W-1:0] tap_phase;
    logic [PHASE_W-1:0] sel_phase;
    edge_ev_t           ev;
    phase_src_e         src;

    phase_counter #(.W(PHASE_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .phase (cnt_phase)
    );

    edge_detect u_edge (
        .clk (clk),
        .din (data_in),
        .ev  (ev)
    );

    therm_coder #(.W(PHASE_W), .TAPS(TAPS)) u_coder (
        .taps (tap_snap),
        .code (tap_phase)
    );

    assign src = phase_src_e'(src_tap);

    always_comb begin
        unique case (src)
            SRC_TAPS:  sel_phase = tap_phase;
            default:   sel_phase = cnt_phase;
        endcase
    end

    // Capture register: one stamp per sampled transition
    always_ff @(posedge clk) begin
        if (rst) begin
            stamp_valid  <= 1'b0;
            stamp_phase  <= '0;
            stamp_rising <= 1'b0;
        end else begin
            stamp_valid <= ev.seen;
            if (ev.seen) begin
                stamp_phase  <= sel_phase;
                stamp_rising <= ev.level;
            end
        end
    end
endmodule

// File: rtl/edge_phase_stamp_chk.sv
module edge_phase_stamp_chk #(
    parameter int PHASE_W = 5,
    parameter int TAPS    = 32
) (
    input logic               clk,
    input logic               rst,
    input logic               data_in,
    input logic               src_tap,
    input logic [TAPS-1:0]    tap_snap,
    input logic               stamp_valid,
    input logic [PHASE_W-1:0] stamp_phase,
    input logic               stamp_rising
);
    localparam logic [PHASE_W-1:0] TOP_STEP = '1;

    logic               prev_d;
    logic [PHASE_W-1:0] chk_cnt;

    always_ff @(posedge clk) begin
        prev_d <= data_in;
        if (rst) chk_cnt <= '0;
        else     chk_cnt <= chk_cnt + 1'b1;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (!stamp_valid && stamp_phase == '0 && !stamp_rising));

    // R5
    valid_edge_chk: assert property (@(posedge clk) disable iff (rst)
        stamp_valid == $past(data_in != prev_d));

    // R3
    level_flag_chk: assert property (@(posedge clk) disable iff (rst)
        stamp_valid |-> stamp_rising == $past(data_in));

    // R2
    count_phase_chk: assert property (@(posedge clk) disable iff (rst)
        (stamp_valid && !$past(src_tap)) |-> stamp_phase == $past(chk_cnt));

    // R8
    all_ones_chk: assert property (@(posedge clk) disable iff (rst)
        (stamp_valid && $past(src_tap) && $past(&tap_snap)) |-> stamp_phase == TOP_STEP);

    // R7
    first_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (stamp_valid && $past(src_tap) && !$past(tap_snap[0])) |-> stamp_phase == '0);

    // R6
    back_to_back_chk: assert property (@(posedge clk) disable iff (rst)
        (stamp_valid && $past(stamp_valid)) |-> stamp_rising != $past(stamp_rising));
endmodule

bind edge_phase_stamp edge_phase_stamp_chk #(.PHASE_W(PHASE_W), .TAPS(TAPS)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .data_in      (data_in),
    .src_tap      (src_tap),
    .tap_snap     (tap_snap),
    .stamp_valid  (stamp_valid),
    .stamp_phase  (stamp_phase),
    .stamp_rising (stamp_rising)
);

// File: tb/sim_edge_phase_stamp.sv
module sim_edge_phase_stamp;
    localparam int CLK_P = 10;
    localparam int PW    = 5;
    localparam int TAPS  = 1 << PW;
    localparam int SEED  = 20240611;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            data_in = 1'b0;
    logic            src_tap = 1'b0;
    logic [TAPS-1:0] tap_snap = '0;
    logic            stamp_valid;
    logic [PW-1:0]   stamp_phase;
    logic            stamp_rising;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit last_edge = 1'b0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    edge_phase_stamp #(.PHASE_W(PW)) u0 (
        .clk(clk), .rst(rst), .data_in(data_in), .src_tap(src_tap),
        .tap_snap(tap_snap), .stamp_valid(stamp_valid),
        .stamp_phase(stamp_phase), .stamp_rising(stamp_rising)
    );

    // Edges since reset release: the counter phase of the next capture
    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Expected tap phase: position of the first zero, top step if none
    function automatic int exp_tap(input logic [TAPS-1:0] t);
        for (int i = 0; i < TAPS; i++) if (!t[i]) return i;
        return TAPS - 1;
    endfunction

    function automatic logic [TAPS-1:0] therm(input int k);
        logic [TAPS-1:0] v = '0;
        for (int i = 0; i < k && i < TAPS; i++) v[i] = 1'b1;
        return v;
    endfunction

    // Apply one cycle of stimulus at a falling edge, judge it at the next
    task automatic step(input logic d, input logic s, input logic [TAPS-1:0] t);
        bit is_edge;
        int ep;
        is_edge = (d != data_in);
        ep = s ? exp_tap(t) : (cyc % TAPS);
        data_in = d; src_tap = s; tap_snap = t;
        @(negedge clk);
        check(stamp_valid == is_edge, "R5 valid strobe", int'(stamp_valid), int'(is_edge));
        if (is_edge) begin
            check(int'(stamp_phase) == ep, s ? "R7 tap phase" : "R2 counter phase",
                  int'(stamp_phase), ep);
            check(stamp_rising == d, d ? "R3 rising flag" : "R4 falling flag",
                  int'(stamp_rising), int'(d));
            if (last_edge)
                check(stamp_valid == 1'b1, "R6 back-to-back stamp", int'(stamp_valid), 1);
        end
        last_edge = is_edge;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(stamp_valid == 1'b0 && stamp_phase == '0 && stamp_rising == 1'b0,
              "R1 reset state", int'({stamp_valid, stamp_rising, stamp_phase}), 0);
        rst = 1'b0;
        last_edge = 1'b0;
    endtask

    initial begin
        int unsigned r;
        logic [PW-1:0] ph_a;
        r = $urandom(SEED);
        @(negedge clk);
        // R1: reset clears outputs, and a toggle during reset is not stamped
        data_in = 1'b1;
        do_reset();
        // R1: first edge after release samples phase 0
        step(1'b0, 1'b0, '0);
        // R2: edges 32 cycles apart share a phase
        ph_a = stamp_phase;
        for (int i = 0; i < TAPS - 1; i++) step(1'b0, 1'b0, '0);
        step(1'b1, 1'b0, '0);
        check(stamp_phase == ph_a, "R2 wrap period", int'(stamp_phase), int'(ph_a));
        // R6: consecutive toggles straddling the counter wrap
        while ((cyc % TAPS) != TAPS - 2) step(data_in, 1'b0, '0);
        for (int i = 0; i < 4; i++) step(~data_in, 1'b0, '0);
        // R7, R8, R9: tap coder corner cases
        step(~data_in, 1'b1, '0);
        step(~data_in, 1'b1, '1);
        check(stamp_phase == PW'(TAPS - 1), "R8 all ones saturate", int'(stamp_phase), TAPS - 1);
        step(~data_in, 1'b1, therm(5) | (TAPS'(1) << 20));
        check(stamp_phase == PW'(5), "R9 bubble ignored", int'(stamp_phase), 5);
        step(~data_in, 1'b1, therm(TAPS - 1));
        step(~data_in, 1'b1, 32'h8000_0000);
        check(stamp_phase == '0, "R7 bit0 clear gives zero", int'(stamp_phase), 0);
        // R5: held level with changing taps gives no stamp
        for (int i = 0; i < 5; i++) step(data_in, 1'b1, 32'($urandom));
        // Mid-run reset then random traffic
        do_reset();
        for (int i = 0; i < 2000; i++) begin
            logic d;
            logic s;
            logic [TAPS-1:0] t;
            int k;
            d = (($urandom % 3) == 0) ? data_in : ~data_in;
            s = 1'($urandom);
            k = int'($urandom % (TAPS + 1));
            t = therm(k);
            if (($urandom % 4) == 0 && k + 2 < TAPS)
                t[k + 2 + int'($urandom % (TAPS - k - 2))] = 1'b1;
            step(d, s, t);
        end
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule